// File: doc/BRIEF.md
# Capture/Compare Interval Timer

This block is a general-purpose up-counter with a prescaler, a choice of counting clock, two capture inputs and three compare outputs. Software sets it up through a small word-addressed register bus. Each counting step is a prescaled tick. A tick happens on every N-th event of the selected source, where N is the programmed divide value plus one.

At a compare match the block raises a status flag and drives its compare output pin in the programmed way. A capture input that sees its chosen edge stores the current count and raises a flag. The counter can run freely, wrapping from all-ones to zero and raising a rollover flag. It can also restart from zero after it matches the first compare value. Status flags are cleared by writing ones to them. A mask register selects which flags reach the single interrupt line. A self-clearing soft-reset bit returns every register to its reset value.

Top module: `cc_timer`

## Requirements
- R1: After `rst_n` is low, every register reads zero, `cmp_out` is 0 and `irq` is low. Byte offsets: 0x00 control, 0x04 divide, 0x08 status, 0x0C interrupt mask, 0x10/0x14/0x18 compare 1..3, 0x1C/0x20 capture 1..2, 0x24 count.
- R2: Status bits are [0..2] compare 1..3, [3..4] capture 1..2 and [5] rollover. Writing 1 to a bit clears it and writing 0 leaves it unchanged. If a new event and a clear land in the same cycle, the event wins.
- R3: `irq` is high exactly when some status bit is set and its bit in the mask register is also set. The mask uses the status bit layout.
- R4: The divide register holds the divide ratio minus one. A tick comes once the prescale counter has reached the divide value, so a smaller value written in the middle of a period takes effect on the next source event.
- R5: Writing control bit 31 sets a soft-reset bit. That bit reads back 1 for one cycle. In the next cycle every register, capture value and compare pin is reset and the bit reads 0.
- R6: Control bit 0 enables counting; while it is 0 the count holds. Control bit 1 selects what happens when bit 0 goes from 0 to 1: if bit 1 is set the count restarts from 0, otherwise it resumes from its held value.
- R7: When control bit 2 is 1 the counter runs freely. A tick at all-ones wraps the count to 0 and sets status bit 5.
- R8: When control bit 2 is 0, a tick taken while the count equals compare 1 loads 0 instead of incrementing.
- R9: Control bits [7:6] and [9:8] set the capture mode for channels 1 and 2: 00 off, 01 rising edge, 10 falling edge, 11 both edges. Each input passes through two synchronizer flops. The latched value is the count two cycles after the pin changes.
- R10: A tick taken while the count equals a compare value sets that channel's flag. It also acts on the channel's pin, with the mode in control bits [12:10], [15:13] and [18:16]: 000 hold, 001 toggle, 010 low, 011 high, 1xx the pin is high except for one low cycle after a match.
- R11: Control bits [5:3] pick the counting source: 1, 2 or 3 the bus clock, 4 the rising edges of the synchronized `ref_clk`, any other value stopped.
- R12: Writes to the count and capture registers have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ref_clk | input | 1 | Low-frequency reference, counting source 4 |
| cap_in | input | 2 | Capture input pins |
| cmp_out | output | 3 | Compare output pins |
| irq | output | 1 | Masked OR of the status flags |

## Verification
In one clock cycle a software clear of a status flag can meet a fresh compare event on that same flag. The bench sets this up with the count wrapping in free-run mode. It times a write of ones to the status register so that its clock edge is the edge at which compare 2 matches again. It then expects the flag to read back set, because the event has priority. The same write clears compare flag 1, which had no event in that cycle. The bench checks that this flag drops, that `irq` follows it down, and that `irq` comes back up two cycles later when compare 1 matches again.

// File: rtl/cct_pkg.sv
package cct_pkg;
    localparam int N_CAP = 2;
    localparam int N_CMP = 3;
    localparam int N_STS = N_CMP + N_CAP + 1;

    localparam int ST_CAP0 = N_CMP;
    localparam int ST_ROV  = N_CMP + N_CAP;

    localparam logic [7:0] A_CTRL = 8'h00;
    localparam logic [7:0] A_DIV  = 8'h04;
    localparam logic [7:0] A_STS  = 8'h08;
    localparam logic [7:0] A_MASK = 8'h0C;
    localparam logic [7:0] A_CMP0 = 8'h10;
    localparam logic [7:0] A_CAP0 = 8'h1C;
    localparam logic [7:0] A_CNT  = 8'h24;

    localparam logic [2:0] SRC_REF = 3'd4;

    localparam int SWR_BIT = 31;

    typedef struct packed {
        logic [2:0] om3;
        logic [2:0] om2;
        logic [2:0] om1;
        logic [1:0] cm2;
        logic [1:0] cm1;
        logic [2:0] src;
        logic       freerun;
        logic       zero_on_en;
        logic       en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/cct_prescaler.sv
module cct_prescaler #(
    parameter int PR_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            restart,
    input  logic            run,
    input  logic [2:0]      src_sel,
    input  logic            ref_clk,
    input  logic [PR_W-1:0] div_m1,
    output logic            tick
);
    import cct_pkg::*;

    typedef struct packed {
        logic [2:0]      ref_sh;
        logic [PR_W-1:0] pc;
    } ps_t;

    ps_t ps_d, ps_q;
    logic src_ev;

    always_comb begin
        ps_d        = ps_q;
        ps_d.ref_sh = {ps_q.ref_sh[1:0], ref_clk};
        if (src_sel == SRC_REF) begin
            src_ev = ps_q.ref_sh[1] & ~ps_q.ref_sh[2];
        end else if (src_sel != 3'd0 && src_sel < SRC_REF) begin
            src_ev = 1'b1;
        end else begin
            src_ev = 1'b0;
        end
        tick = run && src_ev && (ps_q.pc >= div_m1);
        if (clr || restart) begin
            ps_d.pc = '0;
        end else if (tick) begin
            ps_d.pc = '0;
        end else if (run && src_ev) begin
            ps_d.pc = ps_q.pc + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ps_q <= '0;
        else        ps_q <= ps_d;
    end

    // R4
    pc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> ps_q.pc == '0);
endmodule

// File: rtl/cct_capture.sv
module cct_capture #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [1:0]       mode,
    input  logic             pin,
    input  logic [CNT_W-1:0] count,
    output logic             evt,
    output logic [CNT_W-1:0] cap_val
);
    typedef struct packed {
        logic [2:0]       sh;
        logic [CNT_W-1:0] cap;
    } cs_t;

    cs_t cs_d, cs_q;
    logic rise, fall;

    always_comb begin
        cs_d    = cs_q;
        cs_d.sh = {cs_q.sh[1:0], pin};
        rise    = cs_q.sh[1] & ~cs_q.sh[2];
        fall    = ~cs_q.sh[1] & cs_q.sh[2];
        case (mode)
            2'b01:   evt = rise;
            2'b10:   evt = fall;
            2'b11:   evt = rise | fall;
            default: evt = 1'b0;
        endcase
        if (clr)      cs_d.cap = '0;
        else if (evt) cs_d.cap = count;
    end

    assign cap_val = cs_q.cap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cs_q <= '0;
        else        cs_q <= cs_d;
    end

    // R9
    cap_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && !clr) |=> cap_val == $past(count));
endmodule

// File: rtl/cct_cmp_out.sv
module cct_cmp_out (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic [2:0] mode,
    input  logic       evt,
    output logic       pin
);
    logic pin_d, pin_q;

    always_comb begin
        pin_d = pin_q;
        if (clr) begin
            pin_d = 1'b0;
        end else if (mode[2]) begin
            pin_d = ~evt;
        end else if (evt) begin
            case (mode[1:0])
                2'b01:   pin_d = ~pin_q;
                2'b10:   pin_d = 1'b0;
                2'b11:   pin_d = 1'b1;
                default: pin_d = pin_q;
            endcase
        end
    end

    assign pin = pin_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_q <= 1'b0;
        else        pin_q <= pin_d;
    end

    // R10
    drive_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && !clr && mode == 3'b011) |=> pin);
endmodule

// File: rtl/cc_timer.sv
module cc_timer #(
    parameter int CNT_W = 32,
    parameter int PR_W  = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        ref_clk,
    input  logic [1:0]  cap_in,
    output logic [2:0]  cmp_out,
    output logic        irq
);
    import cct_pkg::*;

    typedef struct packed {
        ctrl_t                        ctrl;
        logic                         swr;
        logic [PR_W-1:0]              div;
        logic [N_STS-1:0]             mask;
        logic [N_STS-1:0]             sts;
        logic [N_CMP-1:0][CNT_W-1:0]  cmpv;
        logic [CNT_W-1:0]             cnt;
    } regs_t;

    regs_t r_d, r_q;

    logic                        tick;
    logic                        en_rise;
    logic                        wr_ctrl, wr_sts;
    logic [N_CMP-1:0]            cmp_ev;
    logic [N_CAP-1:0]            cap_ev;
    logic [N_CAP-1:0][CNT_W-1:0] cap_val;
    logic [N_CAP-1:0][1:0]       cap_mode;
    logic [N_CMP-1:0][2:0]       out_mode;
    logic                        wrap;
    logic [N_STS-1:0]            sts_set;

    assign wr_ctrl  = bus_wr && bus_addr == A_CTRL;
    assign wr_sts   = bus_wr && bus_addr == A_STS;
    assign en_rise  = wr_ctrl && !bus_wdata[SWR_BIT] && bus_wdata[0] && !r_q.ctrl.en;
    assign cap_mode = {r_q.ctrl.cm2, r_q.ctrl.cm1};
    assign out_mode = {r_q.ctrl.om3, r_q.ctrl.om2, r_q.ctrl.om1};

    cct_prescaler #(.PR_W(PR_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (r_q.swr),
        .restart (en_rise),
        .run     (r_q.ctrl.en),
        .src_sel (r_q.ctrl.src),
        .ref_clk (ref_clk),
        .div_m1  (r_q.div),
        .tick    (tick)
    );

    for (genvar c = 0; c < N_CAP; c++) begin : g_cap
        cct_capture #(.CNT_W(CNT_W)) u_cap (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (r_q.swr),
            .mode    (cap_mode[c]),
            .pin     (cap_in[c]),
            .count   (r_q.cnt),
            .evt     (cap_ev[c]),
            .cap_val (cap_val[c])
        );
    end

    for (genvar k = 0; k < N_CMP; k++) begin : g_cmp
        assign cmp_ev[k] = tick && (r_q.cnt == r_q.cmpv[k]);
        cct_cmp_out u_out (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (r_q.swr),
            .mode  (out_mode[k]),
            .evt   (cmp_ev[k]),
            .pin   (cmp_out[k])
        );
    end

    assign wrap    = tick && (r_q.cnt == {CNT_W{1'b1}});
    assign sts_set = {wrap, cap_ev, cmp_ev};

    always_comb begin
        r_d = r_q;
        if (r_q.swr) begin
            r_d = '0;
        end else begin
            if (en_rise && bus_wdata[1]) begin
                r_d.cnt = '0;
            end else if (tick) begin
                if (!r_q.ctrl.freerun && cmp_ev[0]) r_d.cnt = '0;
                else                               r_d.cnt = r_q.cnt + 1'b1;
            end
            r_d.sts = r_q.sts & ~(wr_sts ? bus_wdata[N_STS-1:0] : '0);
            r_d.sts = r_d.sts | sts_set;
            if (bus_wr) begin
                case (bus_addr)
                    A_CTRL: begin
                        if (bus_wdata[SWR_BIT]) r_d.swr  = 1'b1;
                        else                    r_d.ctrl = ctrl_t'(bus_wdata[CTRL_W-1:0]);
                    end
                    A_DIV:  r_d.div  = bus_wdata[PR_W-1:0];
                    A_MASK: r_d.mask = bus_wdata[N_STS-1:0];
                    default: begin
                        for (int k = 0; k < N_CMP; k++) begin
                            if (bus_addr == A_CMP0 + 8'(4 * k)) r_d.cmpv[k] = bus_wdata[CNT_W-1:0];
                        end
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL: bus_rdata = {r_q.swr, {(31 - CTRL_W){1'b0}}, r_q.ctrl};
            A_DIV:  bus_rdata = 32'(r_q.div);
            A_STS:  bus_rdata = 32'(r_q.sts);
            A_MASK: bus_rdata = 32'(r_q.mask);
            A_CNT:  bus_rdata = 32'(r_q.cnt);
            default: begin
                for (int k = 0; k < N_CMP; k++) begin
                    if (bus_addr == A_CMP0 + 8'(4 * k)) bus_rdata = 32'(r_q.cmpv[k]);
                end
                for (int c = 0; c < N_CAP; c++) begin
                    if (bus_addr == A_CAP0 + 8'(4 * c)) bus_rdata = 32'(cap_val[c]);
                end
            end
        endcase
    end

    assign irq = |(r_q.sts & r_q.mask);

    // R5
    soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.swr |=> (r_q.ctrl == '0 && r_q.div == '0 && r_q.sts == '0 && !r_q.swr));

    // R7
    rollover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.sts[ST_ROV]) |-> ($past(r_q.cnt) == {CNT_W{1'b1}} && r_q.cnt == '0));

    // R8
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !r_q.ctrl.freerun && r_q.cnt == r_q.cmpv[0] && !r_q.swr) |=> r_q.cnt == '0);

    for (genvar s = 0; s < N_STS; s++) begin : g_sts_chk
        // R2
        flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (r_q.sts[s] && !r_q.swr && !(wr_sts && bus_wdata[s])) |=> r_q.sts[s]);
    end
endmodule

// File: tb/sim_cc_timer.sv
module sim_cc_timer;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ref_clk = 1'b0;
    logic [1:0]  cap_in = '0;
    logic [2:0]  cmp_out;
    logic        irq;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [31:0] exp;
        logic [31:0] mask;
        string       tag;
    } item_t;

    item_t sb[$];
    event  smp;

    always #(CLK_P / 2) clk = ~clk;

    cc_timer #(.CNT_W(8), .PR_W(12)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ref_clk(ref_clk),
        .cap_in(cap_in), .cmp_out(cmp_out), .irq(irq)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    initial begin
        forever begin
            item_t it;
            @(smp);
            it = sb.pop_front();
            check(it.tag, bus_rdata & it.mask, it.exp & it.mask);
        end
    end

    task automatic wr(logic [7:0] a, logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, logic [31:0] m, logic [31:0] e, string tag);
        item_t it;
        bus_addr = a;
        #1;
        it.exp = e; it.mask = m; it.tag = tag;
        sb.push_back(it);
        -> smp;
        #1;
    endtask

    task automatic soft_reset();
        wr(8'h00, 32'h8000_0000);
        rd(8'h00, 32'h8000_0000, 32'h8000_0000, "R5 bit reads 1");
        @(negedge clk);
        rd(8'h00, 32'hFFFF_FFFF, 32'h0, "R5 control cleared");
    endtask

    function automatic logic [31:0] full();
        return 32'hFFFF_FFFF;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        rd(8'h00, full(), 32'h0, "R1 control");
        rd(8'h08, full(), 32'h0, "R1 status");
        rd(8'h24, full(), 32'h0, "R1 count");
        check("R1 pins", {29'h0, cmp_out}, 32'h0);
        check("R1 irq", {31'h0, irq}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R7 free-run wrap, R4 divide by 1
        wr(8'h00, 32'hF);
        repeat (20) @(negedge clk);
        rd(8'h24, full(), 32'd20, "R4 divide by one");
        repeat (235) @(negedge clk);
        rd(8'h24, full(), 32'd255, "R7 at all-ones");
        rd(8'h08, 32'h20, 32'h0, "R7 no rollover yet");
        @(negedge clk);
        rd(8'h24, full(), 32'd0, "R7 wrapped");
        rd(8'h08, 32'h20, 32'h20, "R7 rollover flag");
        wr(8'h08, 32'h0);
        rd(8'h08, 32'h20, 32'h20, "R2 write zero keeps flag");
        wr(8'h08, 32'h20);
        rd(8'h08, 32'h20, 32'h0, "R2 write one clears");

        // R5 soft reset
        soft_reset();
        rd(8'h24, full(), 32'h0, "R5 count cleared");

        // R4 immediate divide change
        wr(8'h04, 32'd7);
        wr(8'h00, 32'hF);
        repeat (8) @(negedge clk);
        rd(8'h24, full(), 32'd1, "R4 divide by eight");
        repeat (5) @(negedge clk);
        wr(8'h04, 32'd1);
        repeat (3) @(negedge clk);
        rd(8'h24, full(), 32'd3, "R4 new divide immediate");
        soft_reset();

        // R6 enable behaviour, R12 read-only writes
        wr(8'h00, 32'hF);
        repeat (9) @(negedge clk);
        wr(8'h00, 32'hE);
        repeat (5) @(negedge clk);
        rd(8'h24, full(), 32'd10, "R6 hold while disabled");
        wr(8'h00, 32'hD);
        repeat (4) @(negedge clk);
        rd(8'h24, full(), 32'd14, "R6 resume from held");
        wr(8'h00, 32'hE);
        wr(8'h24, 32'h55);
        rd(8'h24, full(), 32'd15, "R12 count write ignored");
        wr(8'h1C, 32'h77);
        rd(8'h1C, full(), 32'd0, "R12 capture write ignored");
        wr(8'h00, 32'hF);
        rd(8'h24, full(), 32'd0, "R6 zero on enable");
        soft_reset();

        // R11 clock source
        wr(8'h00, 32'h7);
        repeat (10) @(negedge clk);
        rd(8'h24, full(), 32'd0, "R11 source off");
        wr(8'h00, 32'h27);
        for (int i = 0; i < 5; i++) begin
            repeat (4) @(negedge clk);
            ref_clk = 1'b1;
            repeat (4) @(negedge clk);
            ref_clk = 1'b0;
        end
        repeat (10) @(negedge clk);
        rd(8'h24, full(), 32'd5, "R11 reference edges");
        soft_reset();

        // R8 restart on compare 1
        wr(8'h10, 32'd5);
        wr(8'h00, 32'hB);
        repeat (12) @(negedge clk);
        rd(8'h24, full(), 32'd0, "R8 restarted");
        @(negedge clk);
        rd(8'h24, full(), 32'd1, "R8 counts again");
        rd(8'h08, 32'h1, 32'h1, "R10 compare 1 flag");
        soft_reset();

        // R9 capture edges
        wr(8'h00, 32'h24F);
        repeat (10) @(negedge clk);
        cap_in[0] = 1'b1;
        repeat (10) @(negedge clk);
        rd(8'h1C, full(), 32'd12, "R9 rising capture");
        rd(8'h08, 32'h8, 32'h8, "R9 capture 1 flag");
        cap_in[1] = 1'b1;
        repeat (5) @(negedge clk);
        rd(8'h20, full(), 32'd0, "R9 rising ignored in falling mode");
        rd(8'h08, 32'h10, 32'h0, "R9 no capture 2 flag");
        cap_in[1] = 1'b0;
        repeat (5) @(negedge clk);
        rd(8'h20, full(), 32'd27, "R9 falling capture");
        wr(8'h00, 32'h2CF);
        cap_in[0] = 1'b0;
        repeat (5) @(negedge clk);
        rd(8'h1C, full(), 32'd33, "R9 both-edge capture");
        soft_reset();

        // R10 compare pins, R3 irq, R2 concurrent clear and set
        wr(8'h10, 32'd5);
        wr(8'h14, 32'd3);
        wr(8'h18, 32'd8);
        wr(8'h0C, 32'h1);
        wr(8'h00, 32'h4640F);
        repeat (3) @(negedge clk);
        check("R10 high mode before match", {31'h0, cmp_out[1]}, 32'h0);
        @(negedge clk);
        check("R10 high mode after match", {31'h0, cmp_out[1]}, 32'h1);
        @(negedge clk);
        check("R3 irq low before flag", {31'h0, irq}, 32'h0);
        @(negedge clk);
        check("R10 toggle", {31'h0, cmp_out[0]}, 32'h1);
        check("R3 irq high with mask", {31'h0, irq}, 32'h1);
        repeat (2) @(negedge clk);
        check("R10 pulse idle high", {31'h0, cmp_out[2]}, 32'h1);
        @(negedge clk);
        check("R10 pulse low", {31'h0, cmp_out[2]}, 32'h0);
        @(negedge clk);
        check("R10 pulse back high", {31'h0, cmp_out[2]}, 32'h1);
        repeat (249) @(negedge clk);
        wr(8'h08, 32'h3);
        rd(8'h08, 32'h2, 32'h2, "R2 set wins over clear");
        rd(8'h08, 32'h1, 32'h0, "R2 plain clear");
        check("R3 irq drops", {31'h0, irq}, 32'h0);
        repeat (2) @(negedge clk);
        check("R3 irq returns", {31'h0, irq}, 32'h1);
        check("R10 toggle back", {31'h0, cmp_out[0]}, 32'h0);

        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule